// File: doc/BRIEF.md
# Supply Loss Access Gate

This block sits between the supply monitors of a battery-backed memory and clock module and the host bus logic. It decides, once per clock, whether host accesses may reach the storage and the timekeeper, and which power source feeds them. It has two supply flags, and each passes through its own synchronizer. One flag says the main supply is above the deselect threshold. The other says the main supply is above the lower battery switchover threshold. A free-running timebase pulse sets the length of the recovery wait after power returns.

A small state machine drives the gate. It has three states. In `GATE_DOWN` the supply is low and every access is refused. `GATE_RECOVER` is the wait after the supply returns, timed in timebase ticks. In `GATE_OPEN` accesses pass. The transitions are:
- `T_UP` moves `GATE_DOWN` to `GATE_RECOVER` when the synchronized deselect flag reads high.
- `T_EXPIRE` moves `GATE_RECOVER` to `GATE_OPEN` on the tick that completes the recovery count.
- `T_ABORT` moves `GATE_RECOVER` back to `GATE_DOWN` when the flag drops, and the count then starts again from zero.
- `T_FAIL` moves `GATE_OPEN` to `GATE_DOWN` when the flag drops. Accesses are then cut off with no grace period.

The battery leaves reset disconnected, as it is shipped. It is connected the first time the supply is seen above the deselect threshold, and it stays connected from then on.

Top module: `pfg_access_gate`

## Requirements
- R1: After reset, `access_en`, `batt_sel` and `batt_connected` are all 0 and the state is `GATE_DOWN`.
- R2: Each raw supply flag passes two synchronizer flops before it is used. A change on a raw flag is seen by the decision logic two clock edges later, and it reaches a registered output at the third edge.
- R3: Whenever the synchronized deselect flag is low, `access_en` is 0 from the next clock edge.
- R4: After `T_UP`, `access_en` stays 0 until `RECOVER_TICKS` tick pulses have been sampled in `GATE_RECOVER`. It becomes 1 at the clock edge that samples the last of those ticks. The default of 2000 ticks gives 2 ms with a 1 µs timebase, which lies inside the required 1.5 to 2.5 ms window.
- R5: If the deselect flag drops during `GATE_RECOVER`, the tick count is discarded. A later return of the supply needs the full `RECOVER_TICKS` again.
- R6: In `GATE_OPEN`, `access_en` falls at the first clock edge after the synchronized deselect flag goes low. Nothing holds it up.
- R7: `batt_connected` becomes 1 at the first edge after the synchronized deselect flag first reads high. It then stays 1 until reset, whatever the supply does.
- R8: `batt_sel` is 1 exactly when the synchronized switchover flag was low and the battery was already connected at the previous edge. While the battery is disconnected, it is never selected.
- R9: Tick pulses have no effect in `GATE_DOWN` or `GATE_OPEN`. Only ticks sampled in `GATE_RECOVER` count toward recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the block to its as-shipped state |
| supply_ok_raw | input | 1 | Comparator flag, high while the supply is above the deselect threshold (asynchronous) |
| above_switch_raw | input | 1 | Comparator flag, high while the supply is above the battery switchover threshold (asynchronous) |
| tick | input | 1 | One-cycle timebase pulse used to time recovery |
| access_en | output | 1 | High when host accesses may reach the memory and the clock; low forces deselect |
| batt_sel | output | 1 | High selects the backup battery as the supply source |
| batt_connected | output | 1 | High once the backup battery has been connected |

## Verification
The wrong internal state that does the most harm is a recovery count that is off by one or left stale. It shows at the ports as `access_en` rising one tick early or late, or, after an aborted recovery, rising after fewer than `RECOVER_TICKS` ticks. Directed tick pulses place that edge on an exact cycle, so the error appears within one cycle of the expected rise. A state register stuck in `GATE_OPEN` shows as `access_en` still high three edges after the raw flag falls. A battery latch that fails to stick shows on `batt_connected` and `batt_sel` at the next edge after the supply drops. A random phase compares every cycle with a reference model, so any divergence is caught within a cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        GATE_DOWN    = 2'd0,
        GATE_RECOVER = 2'd1,
        GATE_OPEN    = 2'd2
    } gate_state_e;

    localparam int unsigned PFG_FLAG_COUNT = 2;
    localparam int unsigned PFG_IDX_DESEL  = 0;
    localparam int unsigned PFG_IDX_SWITCH = 1;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pfg_recovery_timer.sv
module pfg_recovery_timer #(
    parameter int unsigned TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);

    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && tick && (cnt_q == LAST);

    // R5: a restarted count never runs past the final value
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R9: the count only moves while recovery runs
    a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0));

endmodule

// File: rtl/pfg_batt_latch.sv
module pfg_batt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic connected
);

    logic conn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         conn_q <= 1'b0;
        else if (supply_ok) conn_q <= 1'b1;
    end

    assign connected = conn_q;

    // R7: once connected the battery stays connected
    a_r7_batt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        conn_q |=> conn_q);

endmodule

// File: rtl/pfg_access_gate.sv
module pfg_access_gate
    import pfg_pkg::*;
#(
    parameter int unsigned RECOVER_TICKS = 2000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_raw,
    input  logic above_switch_raw,
    input  logic tick,
    output logic access_en,
    output logic batt_sel,
    output logic batt_connected
);

    logic [PFG_FLAG_COUNT-1:0] raw_flags;
    logic [PFG_FLAG_COUNT-1:0] sync_flags;
    logic ok_s, sw_s;
    logic expire;
    logic conn;
    gate_state_e state_q, state_d;
    logic access_q, sel_q;

    assign raw_flags[PFG_IDX_DESEL]  = supply_ok_raw;
    assign raw_flags[PFG_IDX_SWITCH] = above_switch_raw;

    pfg_sync #(
        .WIDTH  (PFG_FLAG_COUNT),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_flags),
        .sync_out (sync_flags)
    );

    assign ok_s = sync_flags[PFG_IDX_DESEL];
    assign sw_s = sync_flags[PFG_IDX_SWITCH];

    pfg_recovery_timer #(
        .TICKS (RECOVER_TICKS)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == GATE_RECOVER),
        .tick   (tick),
        .expire (expire)
    );

    pfg_batt_latch batt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (ok_s),
        .connected (conn)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_DOWN;
        else        state_q <= state_d;
    end

    // transitions T_UP, T_EXPIRE, T_ABORT, T_FAIL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_DOWN: begin
                if (ok_s) state_d = GATE_RECOVER;
            end
            GATE_RECOVER: begin
                if (!ok_s)       state_d = GATE_DOWN;
                else if (expire) state_d = GATE_OPEN;
            end
            GATE_OPEN: begin
                if (!ok_s) state_d = GATE_DOWN;
            end
            default: state_d = GATE_DOWN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            access_q <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            access_q <= (state_d == GATE_OPEN);
            sel_q    <= !sw_s && conn;
        end
    end

    assign access_en      = access_q;
    assign batt_sel       = sel_q;
    assign batt_connected = conn;

    // R3: a low supply flag blocks accesses at the next edge
    a_r3_blocked_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ok_s) |=> (!access_en));

    // R4: accesses open only on the edge that ends recovery
    a_r4_open_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> $past(expire));

    // R8: the battery is never selected before it is connected
    a_r8_sel_needs_batt: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> batt_connected);

endmodule

// File: tb/pfg_access_gate_tb_top.sv
module pfg_access_gate_tb_top;

    localparam int N = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ok_raw = 1'b0;
    logic sw_raw = 1'b0;
    logic tick = 1'b0;
    logic access_en, batt_sel, batt_connected;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfg_access_gate #(.RECOVER_TICKS(N), .SYNC_STAGES(2)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .supply_ok_raw    (ok_raw),
        .above_switch_raw (sw_raw),
        .tick             (tick),
        .access_en        (access_en),
        .batt_sel         (batt_sel),
        .batt_connected   (batt_connected)
    );

    // reference model built from the requirements
    logic m_ok1, m_ok2, m_sw1, m_sw2, m_conn, m_acc, m_sel;
    int   m_st, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        logic ok2, sw2;
        if (!rst_n) begin
            m_ok1 = 0; m_ok2 = 0; m_sw1 = 0; m_sw2 = 0;
            m_conn = 0; m_acc = 0; m_sel = 0; m_st = 0; m_cnt = 0;
        end else begin
            ok2 = m_ok2; sw2 = m_sw2;
            m_ok2 = m_ok1; m_ok1 = ok_raw;
            m_sw2 = m_sw1; m_sw1 = sw_raw;
            case (m_st)
                0: if (ok2) begin m_st = 1; m_cnt = 0; end
                1: if (!ok2) m_st = 0;
                   else if (tick) begin
                       if (m_cnt == N - 1) m_st = 2;
                       else m_cnt++;
                   end
                default: if (!ok2) m_st = 0;
            endcase
            m_sel  = !sw2 && m_conn;
            m_conn = m_conn || ok2;
            m_acc  = (m_st == 2);
        end
    end

    function automatic bit flip(int odds);
        return ($urandom_range(0, odds - 1) == 0);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc();
            tick = 1'b0; cyc();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5150));
        cyc(2);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 access_en", access_en, 1'b0);
        chk("R1 batt_sel", batt_sel, 1'b0);
        chk("R1 batt_connected", batt_connected, 1'b0);

        // R9: ticks while down do not count
        pulse_ticks(5);
        chk("R9 access_en down", access_en, 1'b0);

        ok_raw = 1'b1; sw_raw = 1'b1;
        cyc(2);
        chk("R2 batt_connected latency", batt_connected, 1'b0);
        cyc();
        chk("R7 batt_connected set", batt_connected, 1'b1);

        // R5: abort recovery after N-1 ticks
        pulse_ticks(N - 1);
        chk("R4 access_en before end", access_en, 1'b0);
        ok_raw = 1'b0;
        cyc(3);
        ok_raw = 1'b1;
        cyc(3);
        pulse_ticks(N - 1);
        chk("R5 access_en after restart", access_en, 1'b0);
        tick = 1'b1; cyc(); tick = 1'b0;
        chk("R4 access_en on last tick", access_en, 1'b1);

        // R9: ticks while open do nothing
        pulse_ticks(3);
        chk("R9 access_en open", access_en, 1'b1);

        // R8 switchover selection
        sw_raw = 1'b0;
        cyc(2);
        chk("R2 batt_sel latency", batt_sel, 1'b0);
        cyc();
        chk("R8 batt_sel on", batt_sel, 1'b1);
        sw_raw = 1'b1;
        cyc(3);
        chk("R8 batt_sel off", batt_sel, 1'b0);

        // R6 immediate cutoff
        ok_raw = 1'b0;
        cyc(2);
        chk("R2 access_en latency", access_en, 1'b1);
        cyc();
        chk("R6 access_en cut", access_en, 1'b0);
        sw_raw = 1'b0;
        cyc(3);
        chk("R7 batt_connected sticky", batt_connected, 1'b1);
        chk("R8 batt_sel on battery", batt_sel, 1'b1);

        // random phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            chk("R3 access_en model", access_en, m_acc);
            chk("R8 batt_sel model", batt_sel, m_sel);
            chk("R7 batt_connected model", batt_connected, m_conn);
            if (flip(40)) ok_raw = ~ok_raw;
            if (flip(30)) sw_raw = ~sw_raw;
            tick = flip(3);
            cyc();
        end

        // R1: a second reset returns the battery to disconnected
        rst_n = 1'b0;
        cyc();
        chk("R1 batt_connected after reset", batt_connected, 1'b0);
        chk("R1 access_en after reset", access_en, 1'b0);
        finish_run();
    end

endmodule